// File: doc/BRIEF.md
# Reloading 8-bit PWM compare channel

This block is one compare channel of a counter-array timer, fixed in 8-bit pulse-width mode. It owns the shared timebase counter, which advances on cycles when a timebase-enable input is high. The low byte of that counter is compared with a compare register to drive one registered PWM output. The output goes high when the count reaches the compare value and drops when the low byte wraps from 0xFF to 0x00.

The compare value is double-buffered. Software writes the reload byte, and the channel copies it into the live compare byte at every wrap. A new duty cycle therefore starts cleanly at a period boundary. Writing either compare byte also changes the compare-enable bit. A sticky match flag records each comparator match and stays set until software clears it.

Software reaches the channel through a write port and a registered read port that share one 2-bit address map. The duty cycle is (256 − reload) / 256. A reload of 0 gives a constant high output, and clearing compare-enable gives a constant low output.

Top module: `pwm8_channel`

## Requirements
- R1: While the channel is active, the output rises on the clock edge that moves the counter low byte onto the live compare value. It falls on the edge that wraps the low byte from 0xFF to 0x00. The output and the counter change on the same edge.
- R2: At every wrap the live compare byte (address 0) is loaded from the reload byte (address 1). A new reload value therefore affects the output only after the next wrap.
- R3: With a reload value of 0 the match and the wrap fall on the same tick, and the set action wins. The output then stays high through every period.
- R4: With timebase-enable held high, the output is high for exactly 256 − reload ticks out of each 256-tick period that starts at count 0.
- R5: The channel is active only when both compare-enable (mode bit 0) and PWM-enable (mode bit 1) are 1. While it is inactive the output is low on the next edge and no match flag is set.
- R6: On a match tick the match flag (mode bit 7) is set when the channel is active and flag-enable (mode bit 2) is 1. Writing a 0 to bit 7 of the mode register (address 2) clears the flag, and writing a 1 to it leaves the flag unchanged. If a set and a clear fall in the same cycle, the flag is set.
- R7: A write to address 0 clears compare-enable, and a write to address 1 sets compare-enable. If a write to address 0 falls on a wrap, the written byte wins over the reload.
- R8: The counter advances by one only on cycles with timebase-enable high. With timebase-enable low, the counter, the output and the flag hold their values.
- R9: Synchronous active-high reset clears the counter, both compare bytes, all mode bits, the flag and the output.
- R10: The read data, one cycle after the address is presented, gives address 0 the live compare byte, address 1 the reload byte, address 2 the mode byte {flag, 0000, flag-enable, PWM-enable, compare-enable}, and address 3 the counter low byte. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Timebase enable; counter advances when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| cnt_lo | output | 8 | Counter low byte |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |

## Verification
Three pairs of actions can land in the same cycle: a match and a wrap, a hardware flag set and a software flag clear, and a reload and a software write of the live compare byte. The bench forces the first pair with a reload of 0 and expects a constant high output over a measured period. It forces the other two by waiting until the sampled count is exactly one tick before the event, then issuing the write on the next falling edge. It then reads back the flag or the live compare byte and expects the set or the written byte to win. A behavioural model that runs alongside the design also checks every output on every clock.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    REG_CMP_LO = 2'd0,
    REG_CMP_HI = 2'd1,
    REG_MODE   = 2'd2,
    REG_COUNT  = 2'd3
  } reg_sel_e;

  localparam int MODE_CMP_EN  = 0;
  localparam int MODE_PWM_EN  = 1;
  localparam int MODE_FLAG_EN = 2;

  typedef struct packed {
    logic flag_en;
    logic pwm_en;
    logic cmp_en;
  } mode_t;
endpackage

// File: rtl/pwm8_timebase.sv
module pwm8_timebase #(
  parameter int TB_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tb_en,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] next_lo,
  output logic             wrap
);
  logic [TB_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (tb_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_lo  = cnt_q[CNT_W-1:0];
  assign next_lo = cnt_lo + 1'b1;
  assign wrap    = tb_en && (&cnt_lo);

  // counter frozen without timebase enable
  assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tb_en |=> $stable(cnt_q));
endmodule

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             reload,
  input  logic             set_flag,
  input  logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cmp_lo,
  output logic [CNT_W-1:0] cmp_hi,
  output mode_t            mode,
  output logic             flag,
  output logic [CNT_W-1:0] rd_data
);
  localparam int FLAG_BIT = CNT_W - 1;
  localparam int PAD_W    = CNT_W - 4;

  logic clr_flag;
  logic [CNT_W-1:0] mode_byte;

  assign clr_flag  = wr_en && (wr_addr == REG_MODE) && !wr_data[FLAG_BIT];
  assign mode_byte = {flag, {PAD_W{1'b0}}, mode.flag_en, mode.pwm_en, mode.cmp_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
      mode   <= '0;
    end else begin
      if (reload) cmp_lo <= cmp_hi;
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          REG_CMP_LO: begin
            cmp_lo      <= wr_data;
            mode.cmp_en <= 1'b0;
          end
          REG_CMP_HI: begin
            cmp_hi      <= wr_data;
            mode.cmp_en <= 1'b1;
          end
          REG_MODE: begin
            mode.cmp_en  <= wr_data[MODE_CMP_EN];
            mode.pwm_en  <= wr_data[MODE_PWM_EN];
            mode.flag_en <= wr_data[MODE_FLAG_EN];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_addr))
        REG_CMP_LO: rd_data <= cmp_lo;
        REG_CMP_HI: rd_data <= cmp_hi;
        REG_MODE:   rd_data <= mode_byte;
        default:    rd_data <= cnt_lo;
      endcase
    end
  end

  assert_reload_copies_R2: assert property (@(posedge clk) disable iff (rst)
    (reload && !(wr_en && wr_addr == REG_CMP_LO)) |=> (cmp_lo == $past(cmp_hi)));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_flag) |=> flag);
  assert_hi_write_enables_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_CMP_HI) |=> mode.cmp_en);
  assert_lo_write_disables_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_CMP_LO) |=> !mode.cmp_en);
endmodule

// File: rtl/pwm8_compare.sv
module pwm8_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wrap,
  input  logic             active,
  input  logic [CNT_W-1:0] next_lo,
  input  logic [CNT_W-1:0] cmp_lo,
  input  logic [CNT_W-1:0] cmp_hi,
  output logic             match,
  output logic             pwm
);
  logic [CNT_W-1:0] cmp_sel;

  // at a wrap the incoming reload value is the one the new count meets
  assign cmp_sel = wrap ? cmp_hi : cmp_lo;
  assign match   = tick && (next_lo == cmp_sel);

  always_ff @(posedge clk) begin
    if (rst || !active) pwm <= 1'b0;
    else if (match)     pwm <= 1'b1;
    else if (wrap)      pwm <= 1'b0;
  end

  assert_full_duty_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (active && wrap && cmp_hi == '0) |=> pwm);
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
#(
  parameter int TB_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tb_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt_lo,
  output logic             pwm_out,
  output logic             match_flag
);
  logic [CNT_W-1:0] next_lo, cmp_lo, cmp_hi;
  logic             wrap, match, active, set_flag;
  mode_t            mode;

  pwm8_timebase #(.TB_W(TB_W), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .tb_en(tb_en),
    .cnt_lo(cnt_lo), .next_lo(next_lo), .wrap(wrap)
  );

  assign active   = mode.cmp_en && mode.pwm_en;
  assign set_flag = match && active && mode.flag_en;

  pwm8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .reload(wrap), .set_flag(set_flag), .cnt_lo(cnt_lo),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .mode(mode), .flag(match_flag),
    .rd_data(rd_data)
  );

  pwm8_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tb_en), .wrap(wrap), .active(active),
    .next_lo(next_lo), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .match(match), .pwm(pwm_out)
  );

  assert_wrap_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (active && wrap && cmp_hi != '0) |=> !pwm_out);
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwm_out);
  assert_idle_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (!active && !match_flag) |=> !match_flag);
endmodule

// File: tb/sim_pwm8_channel.sv
module sim_pwm8_channel;
  localparam int P = 10;

  logic       clk = 1'b0, rst = 1'b1, tb_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd2;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, cnt_lo;
  logic       pwm_out, match_flag;

  int nchk = 0, nfail = 0;

  // behavioural model state
  int m_cnt, m_lo, m_hi, m_rd;
  bit m_en, m_pe, m_fe, m_flag, m_pwm;

  always #(P/2) clk = ~clk;

  pwm8_channel u0 (
    .clk(clk), .rst(rst), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_lo(cnt_lo),
    .pwm_out(pwm_out), .match_flag(match_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit tick, wrap, match, act;
    int nxt, cmpv;
    if (rst) begin
      m_cnt = 0; m_lo = 0; m_hi = 0; m_rd = 0;
      m_en = 0; m_pe = 0; m_fe = 0; m_flag = 0; m_pwm = 0;
    end else begin
      tick  = tb_en;
      nxt   = (m_cnt + 1) % 256;
      wrap  = tick && (m_cnt == 255);
      cmpv  = wrap ? m_hi : m_lo;
      match = tick && (nxt == cmpv);
      act   = m_en && m_pe;
      case (rd_addr)
        2'd0: m_rd = m_lo;
        2'd1: m_rd = m_hi;
        2'd2: m_rd = {m_flag, 4'b0, m_fe, m_pe, m_en};
        default: m_rd = m_cnt;
      endcase
      if (!act) m_pwm = 0;
      else if (match) m_pwm = 1;
      else if (wrap) m_pwm = 0;
      if (match && act && m_fe) m_flag = 1;
      else if (wr_en && wr_addr == 2'd2 && !wr_data[7]) m_flag = 0;
      if (wrap) m_lo = m_hi;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_lo = wr_data; m_en = 0; end
          2'd1: begin m_hi = wr_data; m_en = 1; end
          2'd2: begin m_en = wr_data[0]; m_pe = wr_data[1]; m_fe = wr_data[2]; end
          default: ;
        endcase
      end
      if (tick) m_cnt = nxt;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #(P/4);
    if (!rst) begin
      check(pwm_out == m_pwm, "R1 model pwm", pwm_out, m_pwm);
      check(match_flag == m_flag, "R6 model flag", match_flag, m_flag);
      check(cnt_lo == m_cnt[7:0], "R8 model count", cnt_lo, m_cnt);
      check(rd_data == m_rd[7:0], "R10 model read", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sample;
    @(posedge clk); #(P/4);
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    do sample(); while (cnt_lo != v);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    sample(); d = rd_data;
  endtask

  task automatic duty(input logic [7:0] h);
    int high;
    wr(2'd1, h);
    wait_cnt(8'h00);
    high = 0;
    for (int i = 0; i < 256; i++) begin
      high += pwm_out;
      sample();
    end
    check(high == 256 - h, (h == 0) ? "R3 full duty" : "R4 duty", high, 256 - h);
  endtask

  initial begin
    #(P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    sample();
    check(pwm_out == 0, "R9 reset pwm", pwm_out, 0);
    check(match_flag == 0, "R9 reset flag", match_flag, 0);
    check(cnt_lo == 0, "R9 reset count", cnt_lo, 0);
    rd(2'd2, d); check(d == 0, "R9 reset mode", d, 0);
    rd(2'd1, d); check(d == 0, "R9 reset reload", d, 0);

    // R8: no ticks, nothing moves
    wr(2'd1, 8'h00); wr(2'd2, 8'h07);
    repeat (20) sample();
    check(cnt_lo == 0 && pwm_out == 0, "R8 frozen", {pwm_out, cnt_lo}, 0);

    @(negedge clk); tb_en = 1;
    wr(2'd2, 8'h03);
    duty(8'h00);
    duty(8'h01);
    duty(8'h40);
    duty(8'hFF);
    duty(8'h80);

    // R2: new reload only after next wrap
    wait_cnt(8'h10);
    wr(2'd1, 8'h20);
    wait_cnt(8'h40);
    check(pwm_out == 0, "R2 old compare kept", pwm_out, 0);
    rd(2'd0, d); check(d == 8'h80, "R2 live byte unchanged", d, 8'h80);
    wait_cnt(8'h00);
    wait_cnt(8'h40);
    check(pwm_out == 1, "R2 new compare after wrap", pwm_out, 1);
    wait_cnt(8'h1F);
    check(pwm_out == 0, "R1 low before match", pwm_out, 0);
    sample();
    check(pwm_out == 1, "R1 rises at match", pwm_out, 1);
    wait_cnt(8'h00);
    check(pwm_out == 0, "R1 falls at wrap", pwm_out, 0);

    // R5: PWM-enable off -> low
    wr(2'd2, 8'h01);
    wait_cnt(8'h80);
    check(pwm_out == 0, "R5 pwm-enable off", pwm_out, 0);

    // R6 flag behaviour
    wr(2'd2, 8'h07);
    wait_cnt(8'h30);
    check(match_flag == 1, "R6 flag set", match_flag, 1);
    wr(2'd2, 8'h87);
    check(match_flag == 1, "R6 write one keeps", match_flag, 1);
    wr(2'd2, 8'h03);
    check(match_flag == 0, "R6 write zero clears", match_flag, 0);
    wait_cnt(8'h30);
    check(match_flag == 0, "R6 no set without flag-enable", match_flag, 0);
    // set and clear on the same edge
    wr(2'd1, 8'h10); wr(2'd2, 8'h07);
    wait_cnt(8'h0F);
    @(negedge clk); wr_en = 1; wr_addr = 2'd2; wr_data = 8'h07;
    @(negedge clk); wr_en = 0;
    check(match_flag == 1, "R6 set wins over clear", match_flag, 1);

    // R7: low write disables, collision with reload
    wait_cnt(8'hFF);
    @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 8'h55;
    @(negedge clk); wr_en = 0;
    rd(2'd0, d); check(d == 8'h55, "R7 write beats reload", d, 8'h55);
    rd(2'd2, d); check(d[0] == 0, "R7 low write clears enable", d[0], 0);
    wait_cnt(8'h80);
    check(pwm_out == 0, "R5 compare-enable off", pwm_out, 0);
    wr(2'd1, 8'h10);
    rd(2'd2, d); check(d[0] == 1, "R7 high write sets enable", d[0], 1);

    // R10: count readback, address 3 write ignored
    wr(2'd3, 8'hAA);
    rd(2'd1, d); check(d == 8'h10, "R10 reload unaffected", d, 8'h10);
    rd(2'd3, d); check(d != 8'hAA || cnt_lo == 8'hAB, "R10 count read", d, cnt_lo);

    // R8: pause mid-period
    @(negedge clk); tb_en = 0;
    sample(); d = cnt_lo;
    repeat (10) sample();
    check(cnt_lo == d, "R8 hold", cnt_lo, d);
    @(negedge clk); tb_en = 1;
    repeat (300) sample();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule